// File: doc/BRIEF.md
# Flash Completion Status Poller

This block sits on the host side of a NOR-style flash device. After software has started an embedded program or erase operation, it decides whether that operation has ended, and how. A start request carries an address inside the area being worked on. The block then reads the device status word at that address again and again over a simple synchronous bus. It watches one status bit that flips on every read while the device is busy, and a second bit that the device raises when its internal time limit is exceeded.

A pair of consecutive reads with a steady toggle bit means the operation is done, and the block pulses a pass flag. A pair that still toggles after the time-limit flag was seen means the operation failed. In that case the block writes the reset command so the device goes back to array reads, and only then pulses a fail flag. A programmable limit on the number of busy polls catches a device that never settles. The host can abort a poll between status checks and start over later.

Top module: `flash_done_poller`

## Requirements
- R1: A start pulse is taken only while `busy` is low. It latches `start_addr` and `wd_limit`, and `busy` is high from the next cycle until the cycle in which a result flag pulses. A start pulse while `busy` is high changes nothing, and `bus_addr` stays at the latched address.
- R2: Every status check is a pair of reads at the latched address. Each read holds `bus_rd` high until a cycle with `bus_rdy` high, and `bus_rdata` is taken in that cycle.
- R3: If bit 6 has the same value in both reads of a pair, `done_pass` pulses for exactly one cycle, in the cycle after the second read is acknowledged. `busy` is low in that cycle and no write is issued.
- R4: If bit 6 differs and bit 5 of the second read of the pair is 0, the block starts a new pair of reads and keeps polling. Bit 5 of the first read of the pair is not used.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly one more pair is read. If bit 6 is steady in that pair, the result is pass whatever bit 5 holds.
- R6: If the extra pair from R5 still shows bit 6 changing, the result is fail.
- R7: On fail, one write is issued with `bus_wdata` equal to 0x00F0 at the latched address, held until acknowledged. `done_fail` pulses for one cycle in the cycle after the write acknowledge.
- R8: Each toggling pair with bit 5 at 0 counts as one busy poll. When the count reaches the latched limit (a limit of 0 acts as 1), the block goes to the R7 fail sequence instead of reading again.
- R9: `abort` during reads returns the block to idle on the next cycle with no result flag. The next start begins with a fresh pair of reads and keeps no toggle value from before. `abort` during the reset write has no effect.
- R10: `aux_status` equals bit 2 of the most recently acknowledged read and has no influence on pass or fail.
- R11: While reset is held, and right after it, `busy`, `bus_rd`, `bus_wr`, `done_pass`, `done_fail` and `aux_status` are all 0.
- R12: `bus_rd` and `bus_wr` are never high together, and `done_pass` and `done_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a status check |
| start_addr | input | AW | Address used for every poll read and for the reset write |
| wd_limit | input | WDW | Limit on busy polls before a forced fail |
| abort | input | 1 | Give up the current poll (ignored during the reset write) |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe, held until `bus_rdy` |
| bus_wr | output | 1 | Write strobe, held until `bus_rdy` |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid when `bus_rdy` is high during a read |
| bus_rdy | input | 1 | Transfer acknowledge |
| busy | output | 1 | A status check is in progress |
| done_pass | output | 1 | One-cycle pulse: the operation completed |
| done_fail | output | 1 | One-cycle pulse: the operation failed and the device was reset |
| aux_status | output | 1 | Bit 2 of the last acknowledged read |

## Verification
The hardest corner is the time-limit flag rising in the same pair in which the toggling stops. A design that declares failure as soon as it sees bit 5, without the extra pair, reports fail on operations that actually finished. A second trap is taking bit 5 from the first read of a pair instead of the second. A design that does this starts the recheck too early and turns a long but healthy poll into a fail. The poll limit is checked at the count where it should just expire and at one below that, so an off-by-one ends the poll one pair early or one pair late. An abort between the two reads of a pair is followed by a new check; a design that resumes at the second read, using the stale first value, issues only one read there.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_A   = 2'd1,
    ST_RD_B   = 2'd2,
    ST_RST_WR = 2'd3
  } fdp_state_e;

  localparam logic [7:0] RST_CMD_BYTE = 8'hF0;

endpackage

// File: rtl/fdp_pair_cmp.sv
module fdp_pair_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cap_first,
  input  logic rd_ack,
  input  logic tgl_bit,
  input  logic lim_bit,
  input  logic aux_bit,
  output logic toggled,
  output logic lim_flag,
  output logic aux_q
);

  logic first_q;
  logic first_d;
  logic first_en;
  logic aux_d;
  logic aux_en;

  always_comb begin
    first_en = clr | cap_first;
    first_d  = clr ? 1'b0 : tgl_bit;
    aux_en   = rd_ack;
    aux_d    = aux_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
    end else if (first_en) begin
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q <= 1'b0;
    end else if (aux_en) begin
      aux_q <= aux_d;
    end
  end

  // compared against the live second read of the pair
  assign toggled  = tgl_bit ^ first_q;
  assign lim_flag = lim_bit;

endmodule

// File: rtl/fdp_iter_wdog.sv
module fdp_iter_wdog #(
  parameter int unsigned WDW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [WDW-1:0] limit_in,
  input  logic           inc,
  output logic           expire_on_inc
);

  localparam logic [WDW-1:0] CNT_MAX = {WDW{1'b1}};

  logic [WDW-1:0] cnt_q;
  logic [WDW-1:0] cnt_d;
  logic           cnt_en;
  logic [WDW-1:0] lim_q;
  logic [WDW:0]   cnt_plus;

  assign cnt_plus      = {1'b0, cnt_q} + {{WDW{1'b0}}, 1'b1};
  assign expire_on_inc = (cnt_plus >= {1'b0, lim_q});

  always_comb begin
    cnt_en = load | inc;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = '0;
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_plus[WDW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
    end else if (load) begin
      lim_q <= limit_in;
    end
  end

endmodule

// File: rtl/fdp_fsm.sv
module fdp_fsm
  import fdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic bus_rdy,
  input  logic toggled,
  input  logic lim_flag,
  input  logic wd_expire,
  output logic accept,
  output logic clr_first,
  output logic cap_first,
  output logic rd_ack,
  output logic wd_inc,
  output logic pass_set,
  output logic fail_set,
  output logic rd_en,
  output logic wr_en,
  output logic busy
);

  fdp_state_e st_q;
  fdp_state_e st_d;
  logic       rchk_q;
  logic       rchk_d;

  always_comb begin
    st_d      = st_q;
    rchk_d    = rchk_q;
    accept    = 1'b0;
    clr_first = 1'b0;
    cap_first = 1'b0;
    rd_ack    = 1'b0;
    wd_inc    = 1'b0;
    pass_set  = 1'b0;
    fail_set  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept    = 1'b1;
          clr_first = 1'b1;
          rchk_d    = 1'b0;
          st_d      = ST_RD_A;
        end
      end
      ST_RD_A: begin
        if (abort) begin
          clr_first = 1'b1;
          rchk_d    = 1'b0;
          st_d      = ST_IDLE;
        end else if (bus_rdy) begin
          rd_ack    = 1'b1;
          cap_first = 1'b1;
          st_d      = ST_RD_B;
        end
      end
      ST_RD_B: begin
        if (abort) begin
          clr_first = 1'b1;
          rchk_d    = 1'b0;
          st_d      = ST_IDLE;
        end else if (bus_rdy) begin
          rd_ack = 1'b1;
          if (!toggled) begin
            pass_set = 1'b1;
            st_d     = ST_IDLE;
          end else if (rchk_q) begin
            st_d = ST_RST_WR;
          end else if (lim_flag) begin
            rchk_d = 1'b1;
            st_d   = ST_RD_A;
          end else begin
            wd_inc = 1'b1;
            st_d   = wd_expire ? ST_RST_WR : ST_RD_A;
          end
        end
      end
      ST_RST_WR: begin
        if (bus_rdy) begin
          fail_set = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rchk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rchk_q <= rchk_d;
    end
  end

  assign rd_en = (st_q == ST_RD_A) || (st_q == ST_RD_B);
  assign wr_en = (st_q == ST_RST_WR);
  assign busy  = (st_q != ST_IDLE);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int unsigned AW      = 24,
  parameter int unsigned DW      = 16,
  parameter int unsigned WDW     = 16,
  parameter int unsigned TGL_POS = 6,
  parameter int unsigned LIM_POS = 5,
  parameter int unsigned AUX_POS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic [WDW-1:0] wd_limit,
  input  logic           abort,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_rdy,
  output logic           busy,
  output logic           done_pass,
  output logic           done_fail,
  output logic           aux_status
);

  localparam logic [DW-1:0] RST_WORD = {{(DW-8){1'b0}}, fdp_pkg::RST_CMD_BYTE};

  logic          accept;
  logic          clr_first;
  logic          cap_first;
  logic          rd_ack;
  logic          wd_inc;
  logic          wd_expire;
  logic          pass_set;
  logic          fail_set;
  logic          rd_en;
  logic          wr_en;
  logic          toggled;
  logic          lim_flag;
  logic [AW-1:0] addr_q;
  logic          unused_rdata_bits;

  assign unused_rdata_bits = ^bus_rdata;

  fdp_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (abort),
    .bus_rdy   (bus_rdy),
    .toggled   (toggled),
    .lim_flag  (lim_flag),
    .wd_expire (wd_expire),
    .accept    (accept),
    .clr_first (clr_first),
    .cap_first (cap_first),
    .rd_ack    (rd_ack),
    .wd_inc    (wd_inc),
    .pass_set  (pass_set),
    .fail_set  (fail_set),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .busy      (busy)
  );

  fdp_pair_cmp u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_first),
    .cap_first (cap_first),
    .rd_ack    (rd_ack),
    .tgl_bit   (bus_rdata[TGL_POS]),
    .lim_bit   (bus_rdata[LIM_POS]),
    .aux_bit   (bus_rdata[AUX_POS]),
    .toggled   (toggled),
    .lim_flag  (lim_flag),
    .aux_q     (aux_status)
  );

  fdp_iter_wdog #(.WDW(WDW)) u_wdog (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (accept),
    .limit_in      (wd_limit),
    .inc           (wd_inc),
    .expire_on_inc (wd_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= start_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pass <= 1'b0;
      done_fail <= 1'b0;
    end else begin
      done_pass <= pass_set;
      done_fail <= fail_set;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_rd    = rd_en;
  assign bus_wr    = wr_en;
  assign bus_wdata = wr_en ? RST_WORD : '0;

endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_rdy,
  input logic          busy,
  input logic          done_pass,
  input logic          done_fail
);

  localparam logic [DW-1:0] CMD_WORD = {{(DW-8){1'b0}}, 8'hF0};

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_done_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pass && done_fail));

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pass || done_fail) |-> !busy);

  p_pass_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_pass |-> $past(bus_rd && bus_rdy));

  p_fail_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_fail |-> $past(bus_wr && bus_rdy));

  p_cmd_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_wdata == CMD_WORD));

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_addr));

  p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> busy);

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd) && !$past(bus_rdy) && !$past(abort)) |-> bus_rd);

  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_wr) && !$past(bus_rdy)) |-> bus_wr);

endmodule

bind flash_done_poller fdp_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .abort     (abort),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdy   (bus_rdy),
  .busy      (busy),
  .done_pass (done_pass),
  .done_fail (done_fail)
);

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int WDW = 16;
  localparam int NV = 10;

  // {bit6 per read[26:19], bit5 per read[18:11], limit[10:7], fail[6], reads[5:2], latency[1:0]}
  localparam logic [26:0] VEC [NV] = '{
    {8'b00000000, 8'b00000000, 4'd5, 1'b0, 4'd2, 2'd0},
    {8'b00000011, 8'b00000000, 4'd5, 1'b0, 4'd2, 2'd1},
    {8'b00001110, 8'b00000000, 4'd5, 1'b0, 4'd4, 2'd2},
    {8'b00000001, 8'b00001110, 4'd5, 1'b0, 4'd4, 2'd0},
    {8'b00001010, 8'b00000010, 4'd5, 1'b1, 4'd4, 2'd1},
    {8'b10101010, 8'b00000000, 4'd2, 1'b1, 4'd4, 2'd0},
    {8'b00000010, 8'b00000000, 4'd0, 1'b1, 4'd2, 2'd3},
    {8'b00111010, 8'b00000101, 4'd5, 1'b0, 4'd6, 2'd1},
    {8'b11100110, 8'b00000000, 4'd4, 1'b0, 4'd8, 2'd0},
    {8'b11100110, 8'b00000000, 4'd3, 1'b1, 4'd6, 2'd2}
  };

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [AW-1:0]  start_addr;
  logic [WDW-1:0] wd_limit;
  logic           abort;
  logic [AW-1:0]  bus_addr;
  logic           bus_rd;
  logic           bus_wr;
  logic [DW-1:0]  bus_wdata;
  logic [DW-1:0]  bus_rdata;
  logic           bus_rdy;
  logic           busy;
  logic           done_pass;
  logic           done_fail;
  logic           aux_status;

  int n_chk = 0;
  int n_bad = 0;

  // device model state
  logic [7:0]    m_t6;
  logic [7:0]    m_t5;
  logic [1:0]    m_lat;
  logic          clr_stats;
  logic [AW-1:0] exp_addr;
  logic [1:0]    wcnt;
  int            rd_cnt;
  int            wr_cnt;
  int            addr_bad;
  logic [DW-1:0] last_wdata;
  logic [AW-1:0] last_waddr;
  logic          b6;
  logic          b5;

  flash_done_poller #(.AW(AW), .DW(DW), .WDW(WDW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .wd_limit   (wd_limit),
    .abort      (abort),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rdy    (bus_rdy),
    .busy       (busy),
    .done_pass  (done_pass),
    .done_fail  (done_fail),
    .aux_status (aux_status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign bus_rdy = (bus_rd || bus_wr) && (wcnt == m_lat);

  always_comb begin
    b6 = (rd_cnt < 8) ? m_t6[rd_cnt[2:0]] : 1'b0;
    b5 = (rd_cnt < 8) ? m_t5[rd_cnt[2:0]] : 1'b0;
    bus_rdata = {8'h3C, 1'b0, b6, b5, 2'b00, ~b6, 2'b01};
  end

  always @(posedge clk) begin
    if (clr_stats) begin
      rd_cnt   <= 0;
      wr_cnt   <= 0;
      addr_bad <= 0;
      wcnt     <= 2'd0;
    end else begin
      if (bus_rdy || !(bus_rd || bus_wr)) wcnt <= 2'd0;
      else wcnt <= wcnt + 2'd1;
      if (bus_rd && bus_rdy) begin
        rd_cnt <= rd_cnt + 1;
        if (bus_addr != exp_addr) addr_bad <= addr_bad + 1;
      end
      if (bus_wr && bus_rdy) begin
        wr_cnt     <= wr_cnt + 1;
        last_wdata <= bus_wdata;
        last_waddr <= bus_addr;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 1:    return "R3";
      2:       return "R4";
      3:       return "R5";
      4:       return "R6";
      5, 6, 9: return "R8";
      7:       return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic load_dev(input logic [7:0] t6, input logic [7:0] t5,
                          input logic [1:0] lat, input logic [AW-1:0] a);
    @(negedge clk);
    m_t6 = t6; m_t5 = t5; m_lat = lat; exp_addr = a;
    clr_stats = 1'b1;
    @(negedge clk);
    clr_stats = 1'b0;
  endtask

  task automatic pulse_start(input logic [AW-1:0] a, input logic [WDW-1:0] lim);
    start = 1'b1; start_addr = a; wd_limit = lim;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!(done_pass || done_fail) && cycles < 400) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    int cyc;
    start = 1'b0; start_addr = '0; wd_limit = '0; abort = 1'b0;
    m_t6 = '0; m_t5 = '0; m_lat = '0; exp_addr = '0; clr_stats = 1'b1;
    last_wdata = '0; last_waddr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "busy in reset", int'(busy), 0);
    chk("R11", "strobes in reset", int'(bus_rd | bus_wr), 0);
    chk("R11", "done flags in reset", int'(done_pass | done_fail), 0);
    chk("R11", "aux in reset", int'(aux_status), 0);
    rst_n = 1'b1;
    clr_stats = 1'b0;
    @(negedge clk);
    chk("R11", "busy after reset", int'(busy), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      logic [AW-1:0] a;
      int nr;
      v  = VEC[i];
      a  = AW'(24'h10_0000 + i * 24'h0135);
      nr = int'(v[5:2]);
      load_dev(v[26:19], v[18:11], v[1:0], a);
      pulse_start(a, WDW'(v[10:7]));
      chk("R1", "busy after start", int'(busy), 1);
      wait_done(cyc);
      chk(vtag(i), "fail outcome", int'(done_fail), int'(v[6]));
      chk(vtag(i), "pass outcome", int'(done_pass), int'(!v[6]));
      chk("R2", "read count", rd_cnt, nr);
      chk("R2", "read address errors", addr_bad, 0);
      chk("R3", "busy at result", int'(busy), 0);
      chk("R7", "reset writes", wr_cnt, int'(v[6]));
      if (v[6]) begin
        chk("R7", "reset write data", int'(last_wdata), 16'h00F0);
        chk("R7", "reset write addr", int'(last_waddr), int'(a));
      end
      chk("R10", "aux bit", int'(aux_status), int'(!v[19 + nr - 1]));
      @(negedge clk);
      chk("R12", "result pulse width", int'(done_pass | done_fail), 0);
    end

    // R1: start while busy is ignored
    load_dev(8'b00000000, 8'b00000000, 2'd3, 24'h00_0AA0);
    pulse_start(24'h00_0AA0, 16'd5);
    pulse_start(24'h00_0BB0, 16'd5);
    chk("R1", "address kept under second start", int'(bus_addr), 24'h00_0AA0);
    wait_done(cyc);
    chk("R1", "pass despite second start", int'(done_pass), 1);
    chk("R1", "reads at first address", addr_bad, 0);
    chk("R1", "reads for one check", rd_cnt, 2);
    @(negedge clk);
    chk("R1", "no second run", int'(busy), 0);

    // R9: abort between the reads of a pair, then fresh start
    load_dev(8'b00000001, 8'b00000000, 2'd2, 24'h00_0CC0);
    pulse_start(24'h00_0CC0, 16'd5);
    cyc = 0;
    while (rd_cnt < 1 && cyc < 50) begin @(negedge clk); cyc++; end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R9", "idle after abort", int'(busy), 0);
    chk("R9", "no result on abort", int'(done_pass | done_fail), 0);
    repeat (4) @(negedge clk);
    chk("R9", "still idle", int'(busy | done_pass | done_fail), 0);
    load_dev(8'b00000000, 8'b00000000, 2'd1, 24'h00_0CC0);
    pulse_start(24'h00_0CC0, 16'd5);
    wait_done(cyc);
    chk("R9", "fresh pair pass", int'(done_pass), 1);
    chk("R9", "fresh pair reads", rd_cnt, 2);

    // R9: abort during the reset write is ignored
    load_dev(8'b00000010, 8'b00000000, 2'd3, 24'h00_0DD0);
    pulse_start(24'h00_0DD0, 16'd1);
    cyc = 0;
    while (!bus_wr && cyc < 50) begin @(negedge clk); cyc++; end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R9", "write kept under abort", int'(bus_wr), 1);
    wait_done(cyc);
    chk("R9", "fail after abort in write", int'(done_fail), 1);
    chk("R7", "one reset write", wr_cnt, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule